// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch will be taken by running two direction predictors side by side and letting a per-branch chooser pick between them. The local side keeps a short outcome history for each branch and uses it to select a 2-bit saturating counter. The global side keeps one shift register of the most recent outcomes of all branches and uses it to select a counter in a second table. For each branch, a table of 2-bit chooser counters records which side has been more accurate, and that side's guess becomes the final prediction.

Fetch presents a branch address on the lookup port. In the same cycle it receives the final direction, a provider flag, and both component guesses. When the branch resolves, the update port takes the address, the real outcome and the two component guesses captured at lookup. On that clock edge the histories, both counter tables and the chooser are trained. Update is non-speculative: the counters are selected with the history state held at update time.

The branch address is the word address with alignment bits already removed. Each table index is an XOR fold of that address: address bit k is XORed into index bit (k mod index width).

Top module: `tbp_top`

## Requirements
- R1: After reset, every lookup reports `lk_taken`=0, `lk_local_pred`=0, `lk_global_pred`=0 and `lk_use_global`=1. All direction counters start at 1 (weakly not taken), all chooser counters start at 2, and all histories are zero.
- R2: Every direction counter and chooser counter is a 2-bit saturating counter (0..3). Its prediction is its upper bit. It steps up on a taken outcome and down on a not-taken one, and holds at 0 and at 3. From a strong state, two contrary outcomes in a row are needed to flip its prediction.
- R3: Each branch has a 4-bit local history entry, selected by the folded address. That entry selects the local counter. On update, the entry shifts left and the outcome enters at bit 0.
- R4: The global history is GHIST_W bits wide (8 by default). On each update it shifts left and the outcome enters at bit 0. In the default variant it alone selects the global counter. In the hashed variant it is XORed with the folded address.
- R5: A chooser counter whose upper bit is 1 selects the global prediction, and `lk_use_global` reports 1. When the two component guesses differ, the chooser steps up if the global guess matched the outcome and steps down otherwise.
- R6: When the two component guesses are equal, the chooser entry is left unchanged.
- R7: On every update, both the local and the global counter are trained with the outcome, whichever side was selected.
- R8: `lk_taken` equals the prediction of the component named by `lk_use_global`.
- R9: While `up_valid` is 0, no history, counter or chooser changes, whatever the other update inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_pc | input | PC_W | Lookup branch word address |
| lk_taken | output | 1 | Final predicted direction |
| lk_use_global | output | 1 | 1 when the global component provided the prediction |
| lk_local_pred | output | 1 | Local component guess |
| lk_global_pred | output | 1 | Global component guess |
| up_valid | input | 1 | Update strobe for a resolved branch |
| up_pc | input | PC_W | Resolved branch word address |
| up_taken | input | 1 | Actual outcome |
| up_local_pred | input | 1 | Local guess captured at lookup |
| up_global_pred | input | 1 | Global guess captured at lookup |

## Verification
The bench builds the block with an 8-bit address, 2-bit local-history and chooser indices, 4-bit local histories and a 4-bit global history. With these sizes every table has 16 entries or fewer. A full sweep of all 256 addresses then covers the reset state of every entry, and a few thousand mixed outcomes drive every counter through both saturation ends and every chooser through both directions. The address fold is exercised as well, because the four chooser rows are each reached through 64 aliasing addresses. An arithmetic model of the counters and histories predicts all four lookup outputs for every step.

// File: rtl/tbp_pkg.sv
package tbp_pkg;
   localparam int CTR_W = 2;
   typedef logic [CTR_W-1:0] ctr_t;

   localparam ctr_t CTR_MIN     = '0;
   localparam ctr_t CTR_MAX     = '1;
   localparam ctr_t CTR_WEAK_NT = ctr_t'(1);
   localparam ctr_t CTR_WEAK_T  = ctr_t'(2);

   // saturating step toward the outcome
   function automatic ctr_t sat_step(ctr_t c, logic up);
      if (up) return (c == CTR_MAX) ? c : c + ctr_t'(1);
      else    return (c == CTR_MIN) ? c : c - ctr_t'(1);
   endfunction
endpackage

// File: rtl/tbp_pc_fold.sv
module tbp_pc_fold #(
   parameter int IN_W  = 16,
   parameter int OUT_W = 4
) (
   input  logic [IN_W-1:0]  addr,
   output logic [OUT_W-1:0] idx
);
   if (OUT_W < 1 || OUT_W > IN_W) begin : g_bad
      $error("tbp_pc_fold: OUT_W must lie in 1..IN_W");
   end

   always_comb begin
      idx = '0;
      for (int k = 0; k < IN_W; k++) begin
         idx[k % OUT_W] = idx[k % OUT_W] ^ addr[k];
      end
   end
endmodule

// File: rtl/tbp_ctr_table.sv
module tbp_ctr_table
   import tbp_pkg::*;
#(
   parameter int   IDX_W = 4,
   parameter ctr_t INIT  = CTR_WEAK_NT
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   output ctr_t             rd_ctr,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic             wr_inc
);
   localparam int DEPTH = 1 << IDX_W;

   ctr_t mem [DEPTH];

   assign rd_ctr = mem[rd_idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= INIT;
      end else if (wr_en) begin
         mem[wr_idx] <= sat_step(mem[wr_idx], wr_inc);
      end
   end
endmodule

// File: rtl/tbp_local_hist.sv
module tbp_local_hist #(
   parameter int IDX_W  = 4,
   parameter int HIST_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [HIST_W-1:0] rd_hist,
   input  logic              up_en,
   input  logic [IDX_W-1:0]  up_idx,
   output logic [HIST_W-1:0] up_hist,
   input  logic              up_taken
);
   localparam int DEPTH = 1 << IDX_W;

   logic [HIST_W-1:0] hist [DEPTH];

   assign rd_hist = hist[rd_idx];
   assign up_hist = hist[up_idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) hist[i] <= '0;
      end else if (up_en) begin
         hist[up_idx] <= {up_hist[HIST_W-2:0], up_taken};
      end
   end
endmodule

// File: rtl/tbp_global_hist.sv
module tbp_global_hist #(
   parameter int HIST_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              up_en,
   input  logic              up_taken,
   output logic [HIST_W-1:0] hist
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     hist <= '0;
      else if (up_en) hist <= {hist[HIST_W-2:0], up_taken};
   end
endmodule

// File: rtl/tbp_top.sv
module tbp_top
   import tbp_pkg::*;
#(
   parameter int PC_W        = 16,
   parameter int LHT_IDX_W   = 4,
   parameter int LHIST_W     = 4,
   parameter int GHIST_W     = 8,
   parameter int CHS_IDX_W   = 4,
   parameter bit GLOBAL_HASH = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PC_W-1:0] lk_pc,
   output logic            lk_taken,
   output logic            lk_use_global,
   output logic            lk_local_pred,
   output logic            lk_global_pred,
   input  logic            up_valid,
   input  logic [PC_W-1:0] up_pc,
   input  logic            up_taken,
   input  logic            up_local_pred,
   input  logic            up_global_pred
);
   localparam int MSB = CTR_W - 1;

   if (LHIST_W < 2 || GHIST_W < 2) begin : g_bad_hist
      $error("tbp_top: history widths must be at least 2");
   end
   if (PC_W < LHT_IDX_W || PC_W < CHS_IDX_W) begin : g_bad_pc
      $error("tbp_top: PC_W narrower than a table index");
   end
   if (GLOBAL_HASH && PC_W < GHIST_W) begin : g_bad_hash
      $error("tbp_top: hashed global index needs PC_W >= GHIST_W");
   end

   // ---------------- address folding ----------------
   logic [LHT_IDX_W-1:0] lk_lidx, up_lidx;
   logic [CHS_IDX_W-1:0] lk_cidx, up_cidx;

   tbp_pc_fold #(.IN_W(PC_W), .OUT_W(LHT_IDX_W)) u_fold_lk_l (.addr(lk_pc), .idx(lk_lidx));
   tbp_pc_fold #(.IN_W(PC_W), .OUT_W(LHT_IDX_W)) u_fold_up_l (.addr(up_pc), .idx(up_lidx));
   tbp_pc_fold #(.IN_W(PC_W), .OUT_W(CHS_IDX_W)) u_fold_lk_c (.addr(lk_pc), .idx(lk_cidx));
   tbp_pc_fold #(.IN_W(PC_W), .OUT_W(CHS_IDX_W)) u_fold_up_c (.addr(up_pc), .idx(up_cidx));

   // ---------------- local component ----------------
   logic [LHIST_W-1:0] lk_lhist, up_lhist;
   ctr_t               lk_lctr;

   tbp_local_hist #(.IDX_W(LHT_IDX_W), .HIST_W(LHIST_W)) u_lhist (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_idx  (lk_lidx),
      .rd_hist (lk_lhist),
      .up_en   (up_valid),
      .up_idx  (up_lidx),
      .up_hist (up_lhist),
      .up_taken(up_taken)
   );

   tbp_ctr_table #(.IDX_W(LHIST_W), .INIT(CTR_WEAK_NT)) u_lctr (
      .clk   (clk),
      .rst_n (rst_n),
      .rd_idx(lk_lhist),
      .rd_ctr(lk_lctr),
      .wr_en (up_valid),
      .wr_idx(up_lhist),
      .wr_inc(up_taken)
   );

   // ---------------- global component ----------------
   logic [GHIST_W-1:0] ghist_q;
   logic [GHIST_W-1:0] lk_gidx, up_gidx;
   ctr_t               lk_gctr;

   tbp_global_hist #(.HIST_W(GHIST_W)) u_ghist (
      .clk     (clk),
      .rst_n   (rst_n),
      .up_en   (up_valid),
      .up_taken(up_taken),
      .hist    (ghist_q)
   );

   if (GLOBAL_HASH) begin : g_hashed
      logic [GHIST_W-1:0] lk_gfold, up_gfold;
      tbp_pc_fold #(.IN_W(PC_W), .OUT_W(GHIST_W)) u_fold_lk_g (.addr(lk_pc), .idx(lk_gfold));
      tbp_pc_fold #(.IN_W(PC_W), .OUT_W(GHIST_W)) u_fold_up_g (.addr(up_pc), .idx(up_gfold));
      assign lk_gidx = ghist_q ^ lk_gfold;
      assign up_gidx = ghist_q ^ up_gfold;
   end else begin : g_plain
      assign lk_gidx = ghist_q;
      assign up_gidx = ghist_q;
   end

   tbp_ctr_table #(.IDX_W(GHIST_W), .INIT(CTR_WEAK_NT)) u_gctr (
      .clk   (clk),
      .rst_n (rst_n),
      .rd_idx(lk_gidx),
      .rd_ctr(lk_gctr),
      .wr_en (up_valid),
      .wr_idx(up_gidx),
      .wr_inc(up_taken)
   );

   // ---------------- chooser ----------------
   ctr_t lk_chs;
   logic chs_train;
   logic chs_toward_global;

   assign chs_train         = up_valid && (up_local_pred != up_global_pred);
   assign chs_toward_global = (up_global_pred == up_taken);

   tbp_ctr_table #(.IDX_W(CHS_IDX_W), .INIT(CTR_WEAK_T)) u_chooser (
      .clk   (clk),
      .rst_n (rst_n),
      .rd_idx(lk_cidx),
      .rd_ctr(lk_chs),
      .wr_en (chs_train),
      .wr_idx(up_cidx),
      .wr_inc(chs_toward_global)
   );

   // ---------------- outputs ----------------
   assign lk_local_pred  = lk_lctr[MSB];
   assign lk_global_pred = lk_gctr[MSB];
   assign lk_use_global  = lk_chs[MSB];
   assign lk_taken       = lk_use_global ? lk_global_pred : lk_local_pred;
endmodule

// File: rtl/tbp_checker.sv
module tbp_checker #(
   parameter int PC_W    = 16,
   parameter int GHIST_W = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic [PC_W-1:0]    lk_pc,
   input logic               lk_taken,
   input logic               lk_use_global,
   input logic               up_valid,
   input logic [PC_W-1:0]    up_pc,
   input logic               up_taken,
   input logic               up_local_pred,
   input logic               up_global_pred,
   input logic [GHIST_W-1:0] ghist_q
);
   // the global history takes the outcome at bit 0 and moves the rest up
   assert_ghist_shift_R4: assert property (@(posedge clk) disable iff (!rst_n)
      up_valid |=> (ghist_q == {$past(ghist_q[GHIST_W-2:0]), $past(up_taken)}));

   // with no update strobe nothing visible moves
   assert_idle_ghist_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !up_valid |=> $stable(ghist_q));

   assert_idle_lookup_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !up_valid |=> ($stable(lk_pc) -> ($stable(lk_taken) && $stable(lk_use_global))));

   // agreement leaves every chooser entry as it was
   assert_agree_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (up_valid && (up_local_pred == up_global_pred)) |=>
      ($stable(lk_pc) -> $stable(lk_use_global)));

   // a correct global guess on disagreement never turns the chooser away from global
   assert_global_win_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (up_valid && (up_local_pred != up_global_pred) && (up_global_pred == up_taken)
       && (lk_pc == up_pc) && lk_use_global) |=>
      ($stable(lk_pc) -> lk_use_global));

   // and a correct local guess never turns it away from local
   assert_local_win_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (up_valid && (up_local_pred != up_global_pred) && (up_local_pred == up_taken)
       && (lk_pc == up_pc) && !lk_use_global) |=>
      ($stable(lk_pc) -> !lk_use_global));
endmodule

bind tbp_top tbp_checker #(.PC_W(PC_W), .GHIST_W(GHIST_W)) u_tbp_checker (
   .clk           (clk),
   .rst_n         (rst_n),
   .lk_pc         (lk_pc),
   .lk_taken      (lk_taken),
   .lk_use_global (lk_use_global),
   .up_valid      (up_valid),
   .up_pc         (up_pc),
   .up_taken      (up_taken),
   .up_local_pred (up_local_pred),
   .up_global_pred(up_global_pred),
   .ghist_q       (ghist_q)
);

// File: tb/tbp_top_test.sv
`timescale 1ns/1ps
module tbp_top_test;
   localparam int PC_W = 8;
   localparam int LIW  = 2;
   localparam int LHW  = 4;
   localparam int GHW  = 4;
   localparam int CIW  = 2;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [PC_W-1:0] lk_pc = '0;
   logic            lk_taken, lk_use_global, lk_local_pred, lk_global_pred;
   logic            up_valid = 1'b0;
   logic [PC_W-1:0] up_pc = '0;
   logic            up_taken = 1'b0;
   logic            up_local_pred = 1'b0;
   logic            up_global_pred = 1'b0;

   always #2 clk = ~clk;

   tbp_top #(
      .PC_W(PC_W), .LHT_IDX_W(LIW), .LHIST_W(LHW), .GHIST_W(GHW),
      .CHS_IDX_W(CIW), .GLOBAL_HASH(1'b0)
   ) uut (
      .clk(clk), .rst_n(rst_n),
      .lk_pc(lk_pc), .lk_taken(lk_taken), .lk_use_global(lk_use_global),
      .lk_local_pred(lk_local_pred), .lk_global_pred(lk_global_pred),
      .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken),
      .up_local_pred(up_local_pred), .up_global_pred(up_global_pred)
   );

   // arithmetic model built from the requirements
   int m_lh  [1<<LIW];
   int m_lc  [1<<LHW];
   int m_gc  [1<<GHW];
   int m_cs  [1<<CIW];
   int m_gh;

   int nchk  = 0;
   int nfail = 0;
   bit done  = 0;

   function automatic int fold(logic [PC_W-1:0] a, int w);
      int r = 0;
      for (int k = 0; k < PC_W; k++) r = r ^ (int'(a[k]) << (k % w));
      return r;
   endfunction

   function automatic int sat(int c, bit up);
      if (up) return (c == 3) ? 3 : c + 1;
      return (c == 0) ? 0 : c - 1;
   endfunction

   task automatic chk(string tag, logic act, logic exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s pc=%0d: actual %b expected %b", tag, lk_pc, act, exp);
      end
   endtask

   task automatic model_reset();
      foreach (m_lh[i]) m_lh[i] = 0;
      foreach (m_lc[i]) m_lc[i] = 1;
      foreach (m_gc[i]) m_gc[i] = 1;
      foreach (m_cs[i]) m_cs[i] = 2;
      m_gh = 0;
   endtask

   // compare all four lookup outputs against the model
   task automatic check_lookup(output bit lp, output bit gp);
      int li = fold(lk_pc, LIW);
      int ci = fold(lk_pc, CIW);
      bit ug;
      lp = m_lc[m_lh[li]][1];   // R3 local counter via local history
      gp = m_gc[m_gh][1];       // R4 global counter via global history
      ug = m_cs[ci][1];
      chk("R3 R2 R7 local guess", lk_local_pred, lp);
      chk("R4 R2 R7 global guess", lk_global_pred, gp);
      chk("R5 R6 provider", lk_use_global, ug);
      chk("R8 final", lk_taken, ug ? gp : lp);
   endtask

   task automatic step(logic [PC_W-1:0] pc, bit t);
      bit lp, gp;
      int li, ci;
      @(negedge clk);
      up_valid = 1'b0;
      lk_pc = pc;
      #1;
      check_lookup(lp, gp);
      up_pc = pc; up_taken = t; up_local_pred = lp; up_global_pred = gp;
      up_valid = 1'b1;
      li = fold(pc, LIW);
      ci = fold(pc, CIW);
      // R7: both sides trained with the outcome
      m_lc[m_lh[li]] = sat(m_lc[m_lh[li]], t);
      m_gc[m_gh]     = sat(m_gc[m_gh], t);
      // R5/R6: chooser moves only on disagreement
      if (lp != gp) m_cs[ci] = sat(m_cs[ci], gp == t);
      m_lh[li] = ((m_lh[li] << 1) | int'(t)) & ((1 << LHW) - 1);
      m_gh     = ((m_gh << 1) | int'(t)) & ((1 << GHW) - 1);
   endtask

   // R9: junk on the update inputs with the strobe low changes nothing
   task automatic idle(logic [PC_W-1:0] pc, int cyc, logic [15:0] junk);
      bit lp, gp;
      @(negedge clk);
      up_valid = 1'b0;
      lk_pc = pc;
      for (int i = 0; i < cyc; i++) begin
         up_pc = junk[7:0] ^ PC_W'(i);
         up_taken = junk[i % 16];
         up_local_pred = junk[(i + 3) % 16];
         up_global_pred = ~junk[(i + 5) % 16];
         @(negedge clk);
      end
      #1;
      nchk++;
      if (lk_taken !== (m_cs[fold(pc, CIW)][1] ? m_gc[m_gh][1] : m_lc[m_lh[fold(pc, LIW)]][1])) begin
         nfail++;
         $display("FAIL R9 idle pc=%0d: actual %b expected unchanged model value", pc, lk_taken);
      end
      check_lookup(lp, gp);
   endtask

   initial begin
      #200000;
      if (!done) begin
         nfail++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   end

   initial begin
      logic [15:0] lfsr = 16'hACE1;
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state over every address
      for (int p = 0; p < (1 << PC_W); p++) begin
         @(negedge clk);
         lk_pc = PC_W'(p);
         #1;
         chk("R1 reset final", lk_taken, 1'b0);
         chk("R1 reset provider", lk_use_global, 1'b1);
         chk("R1 reset local", lk_local_pred, 1'b0);
         chk("R1 reset global", lk_global_pred, 1'b0);
      end

      // R2: saturation on one branch, then contrary outcomes
      for (int i = 0; i < 6; i++) step(8'h00, 1'b1);
      step(8'h00, 1'b0);
      step(8'h00, 1'b0);
      step(8'h00, 1'b0);
      for (int i = 0; i < 6; i++) step(8'h00, 1'b0);

      // loop shape: taken three times then exit
      for (int i = 0; i < 40; i++) begin
         step(8'h11, 1'b1); step(8'h11, 1'b1); step(8'h11, 1'b1); step(8'h11, 1'b0);
      end
      idle(8'h11, 5, lfsr);

      // alternating branch interleaved with a steady one
      for (int i = 0; i < 80; i++) begin
         step(8'h26, (i % 2) == 1);
         step(8'h3B, 1'b1);
      end
      idle(8'h26, 4, 16'h5A5A);

      // mixed traffic with correlated outcomes
      for (int i = 0; i < 3000; i++) begin
         logic [PC_W-1:0] pc;
         bit t;
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         pc = lfsr[7:0];
         t = pc[0] ? m_gh[1] : (pc[1] ? lfsr[9] : 1'b1);
         step(pc, t);
         if (i % 500 == 499) idle(pc, 3, lfsr);
      end

      @(negedge clk);
      up_valid = 1'b0;
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end
endmodule